// File: doc/BRIEF.md
# I/O Page Table Translation Engine

This block turns a device's 32-bit virtual DMA address into a 36-bit physical address. It does this by fetching one entry from a single-level translation table kept in system memory. A request holds a virtual address and a direction flag (read or write). The engine finds the table entry that covers the request's 4 KB page by combining a base register value, a window size code and the virtual address. It then reads that 32-bit entry through a small memory read port and checks the entry's permission bits. The result is either a translated address or a fault.

The engine works on one request at a time, and it reports `busy` from acceptance until its answer has been taken. The request, memory-fetch and response interfaces use valid/ready handshakes:
- A request is taken on the edge where `req_valid` and `req_ready` are both high.
- `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen.
- A response stays on the outputs, unchanged, until `rsp_ready` is seen.

Memory data has no back-pressure: the engine always takes `mem_rsp_valid` while it waits.

On a fault, the engine pulses `flt_strobe`. The register block uses this pulse to load the fault status word and the fault address, and to raise its interrupt.

Top module: `iopt_walker`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle, `busy` is high and `req_ready` is low until the response handshake completes.
- R2: The entry address equals `{cfg_base, 4'b0}` plus four times the page index. The page index is `(vaddr & ~win_start) >> 12`, where `win_start` is all-ones shifted left by 24+`cfg_win` (code 0 gives a 16 MB window, code 7 a 2 GB window). `cfg_base` and `cfg_win` are sampled when the request is taken, so later changes do not affect a walk in progress.
- R3: Each request makes exactly one memory fetch. `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R4: A good translation returns `rsp_paddr = {entry[31:8], vaddr[11:0]}`. Entry bit 7 (cacheable) and bit 0 (write-as-zero) have no effect on the result.
- R5: If entry bit 1 (valid) is clear, any access faults. If bit 1 is set and bit 2 (writable) is clear, a write faults but a read does not.
- R6: On a fault, `flt_strobe` is high for exactly one cycle, the first cycle of the response. Alongside it:
  - `flt_status` is 0xD0820000 for a write and 0xD0860000 for a read (bit 18 marks a read).
  - `flt_addr` is the virtual address with bits 11:0 cleared.
  
  A request that does not fault gives no strobe.
- R7: `rsp_valid`, `rsp_fault` and `rsp_paddr` stay stable until `rsp_ready` is seen. `rsp_paddr` is zero when `rsp_fault` is set.
- R8: `rsp_valid` rises exactly two clock edges after the edge that takes `mem_rsp_valid`.
- R9: After reset, `busy`, `rsp_valid`, `mem_req_valid` and `flt_strobe` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Table base register value (byte address is this value shifted left by 4) |
| cfg_win | input | 3 | Window size code, 16 MB shifted left by the code |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_vaddr | input | 32 | Virtual address of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_req_valid | output | 1 | Entry fetch requested |
| mem_req_ready | input | 1 | Memory has taken the fetch |
| mem_req_addr | output | 36 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | 32 | Table entry, already assembled into a 32-bit word |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | The request faulted |
| rsp_paddr | output | 36 | Physical address (zero on a fault) |
| busy | output | 1 | A walk is in progress |
| flt_strobe | output | 1 | One-cycle pulse: load the fault registers and raise the interrupt |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting virtual address |

## Verification
The response is due exactly two edges after the edge that takes the memory data. The bench records the cycle count at the falling edge where it drives `mem_rsp_valid`, and it requires `rsp_valid` to be seen first at the falling edge two counts later. The fault strobe and fault words are checked at that same falling edge. The entry address is captured at the falling edge just before the fetch handshake edge. `busy` is checked one falling edge after the request edge and one falling edge after the response handshake. All inputs change on falling edges only, so every sample falls half a period away from the edge that produces it.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int VA_W      = 32;
  localparam int MA_W      = 36;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 32;
  localparam int WIN_W     = 3;
  localparam int PG_SHIFT  = 12;
  localparam int WIN_MIN   = 24;
  localparam int ENT_VALID = 1;
  localparam int ENT_WRITE = 2;
  localparam int RD_FLAG   = 18;
  localparam logic [31:0] FLT_WORD = 32'hD082_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_CHECK, ST_RESP
  } walk_st_e;
endpackage

// File: rtl/iopt_index.sv
module iopt_index #(
  parameter int VA_W    = 32,
  parameter int MA_W    = 36,
  parameter int WIN_W   = 3,
  parameter int PG      = 12,
  parameter int WIN_MIN = 24
) (
  input  logic [VA_W-1:0]  base,
  input  logic [WIN_W-1:0] win,
  input  logic [VA_W-1:0]  vaddr,
  output logic [MA_W-1:0]  pte_addr
);
  localparam int SH = MA_W - VA_W;

  logic [VA_W-1:0] low_mask;
  logic [VA_W-1:0] word_off;

  always_comb begin
    low_mask = ~({VA_W{1'b1}} << (WIN_MIN + int'(win)));
    word_off = ((vaddr & low_mask) >> PG) << 2;
    pte_addr = {base, {SH{1'b0}}} + MA_W'(word_off);
  end
endmodule

// File: rtl/iopt_judge.sv
module iopt_judge
  import iopt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 36,
  parameter int ENT_W = 32,
  parameter int PG    = 12
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             is_wr,
  output logic             fault,
  output logic [PA_W-1:0]  paddr,
  output logic [31:0]      status,
  output logic [VA_W-1:0]  faddr
);
  localparam int PFN_W   = PA_W - PG;
  localparam int PFN_LSB = ENT_W - PFN_W;

  always_comb begin
    fault  = !entry[ENT_VALID] || (is_wr && !entry[ENT_WRITE]);
    paddr  = {entry[ENT_W-1:PFN_LSB], vaddr[PG-1:0]};
    status = FLT_WORD;
    if (!is_wr) status[RD_FLAG] = 1'b1;
    faddr  = {vaddr[VA_W-1:PG], {PG{1'b0}}};
  end
endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
  import iopt_pkg::*;
#(
  parameter int VA_W  = iopt_pkg::VA_W,
  parameter int MA_W  = iopt_pkg::MA_W,
  parameter int PA_W  = iopt_pkg::PA_W,
  parameter int ENT_W = iopt_pkg::ENT_W,
  parameter int WIN_W = iopt_pkg::WIN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  cfg_base,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [MA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             busy,
  output logic             flt_strobe,
  output logic [31:0]      flt_status,
  output logic [VA_W-1:0]  flt_addr
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q;
  logic [MA_W-1:0]  ea_q;
  logic [ENT_W-1:0] ent_q;
  logic             fault_q, strobe_q;
  logic [PA_W-1:0]  pa_q;
  logic [31:0]      stat_q;
  logic [VA_W-1:0]  fa_q;

  logic [MA_W-1:0]  ea_c;
  logic             fault_c;
  logic [PA_W-1:0]  pa_c;
  logic [31:0]      stat_c;
  logic [VA_W-1:0]  fa_c;

  iopt_index #(.VA_W(VA_W), .MA_W(MA_W), .WIN_W(WIN_W), .PG(PG_SHIFT), .WIN_MIN(WIN_MIN)) u_index (
    .base(cfg_base), .win(cfg_win), .vaddr(req_vaddr), .pte_addr(ea_c)
  );

  iopt_judge #(.VA_W(VA_W), .PA_W(PA_W), .ENT_W(ENT_W), .PG(PG_SHIFT)) u_judge (
    .entry(ent_q), .vaddr(va_q), .is_wr(wr_q),
    .fault(fault_c), .paddr(pa_c), .status(stat_c), .faddr(fa_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      ea_q     <= '0;
      ent_q    <= '0;
      fault_q  <= 1'b0;
      strobe_q <= 1'b0;
      pa_q     <= '0;
      stat_q   <= '0;
      fa_q     <= '0;
    end else begin
      strobe_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          wr_q <= req_write;
          ea_q <= ea_c;
          st_q <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          ent_q <= mem_rsp_data;
          st_q  <= ST_CHECK;
        end
        ST_CHECK: begin
          fault_q  <= fault_c;
          pa_q     <= fault_c ? '0 : pa_c;
          strobe_q <= fault_c;
          if (fault_c) begin
            stat_q <= stat_c;
            fa_q   <= fa_c;
          end
          st_q <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == ST_IDLE);
  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign mem_req_addr  = ea_q;
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_paddr     = pa_q;
  assign flt_strobe    = strobe_q;
  assign flt_status    = stat_q;
  assign flt_addr      = fa_q;

  AST_TAKE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready); // R1
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr)); // R7
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0); // R7
  AST_STROBE_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    flt_strobe |-> rsp_valid && rsp_fault && !$past(rsp_valid)); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_strobe |=> !flt_strobe); // R6
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_rsp_valid, 2)); // R8
endmodule

// File: tb/sim_iopt_walker.sv
`timescale 1ns/1ps
module sim_iopt_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_win = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready, mem_req_valid, busy, rsp_valid, rsp_fault, flt_strobe;
  logic        mem_req_ready, mem_rsp_valid, rsp_ready = 1'b0;
  logic [35:0] mem_req_addr, rsp_paddr;
  logic [31:0] mem_rsp_data, flt_status, flt_addr;

  iopt_walker u0 (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_win(cfg_win),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .busy(busy), .flt_strobe(flt_strobe), .flt_status(flt_status), .flt_addr(flt_addr)
  );

  always #2.5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc++;

  int total = 0, bad = 0;
  logic [31:0] pt [64];
  logic [31:0] base_at_req = '0;
  localparam logic [31:0] BASE_MASK = 32'h07FF_FC00;

  function automatic logic [31:0] lookup(input logic [35:0] a);
    logic [35:0] off = a - {base_at_req, 4'b0};
    if (off[1:0] == 2'b00 && off < 36'd256) return pt[off[7:2]];
    return 32'h0;
  endfunction

  function automatic logic [35:0] exp_ea(input logic [31:0] b, input logic [2:0] w, input logic [31:0] va);
    logic [31:0] lo = ~(32'hFFFF_FFFF << (24 + int'(w)));
    return {b, 4'b0} + 36'(((va & lo) >> 12) << 2);
  endfunction

  function automatic logic [31:0] gen_va(input logic [2:0] w, input int idx, input logic [11:0] off);
    logic [31:0] hi = 32'hFFFF_FFFF << (24 + int'(w));
    return ($urandom & hi) | (32'(idx) << 12) | 32'(off);
  endfunction

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  // memory model: random accept and random latency
  int fetches = 0, rsp_cyc = 0, dly = 0;
  bit hs_next = 0, pending = 0;
  logic [35:0] lat_addr = '0, got_addr = '0;
  initial begin
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pending) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = lookup(lat_addr);
          pending = 0; rsp_cyc = cyc;
        end else dly--;
      end
      if (hs_next) begin pending = 1; dly = $urandom % 3; hs_next = 0; end
      mem_req_ready = ($urandom % 2) == 1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        hs_next = 1; lat_addr = mem_req_addr; got_addr = mem_req_addr; fetches++;
      end
    end
  end

  int strobes = 0;
  always @(negedge clk) if (flt_strobe) strobes++;

  task automatic run(input logic [31:0] va, input bit wr, input bit scramble);
    logic [35:0] ea, epa;
    logic [31:0] ent;
    bit ef;
    int f0, s0, hold;
    ea = exp_ea(cfg_base, cfg_win, va);
    base_at_req = cfg_base;
    ent = lookup(ea);
    ef  = !ent[1] || (wr && !ent[2]);
    epa = ef ? 36'h0 : {ent[31:8], va[11:0]};
    f0 = fetches; s0 = strobes;
    @(negedge clk);
    chk("R1 ready while idle", 64'(req_ready), 1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after take", 64'(busy), 1);
    chk("R1 ready low while busy", 64'(req_ready), 0);
    if (scramble) begin cfg_base = $urandom & BASE_MASK; cfg_win = 3'($urandom); end
    while (!rsp_valid) @(negedge clk);
    chk("R2 entry address", 64'(got_addr), 64'(ea));
    chk("R3 one fetch", 64'(fetches - f0), 1);
    chk("R8 latency", 64'(cyc - rsp_cyc), 2);
    chk("R5 fault flag", 64'(rsp_fault), 64'(ef));
    chk("R4 physical address", 64'(rsp_paddr), 64'(epa));
    chk("R6 strobe", 64'(flt_strobe), 64'(ef));
    if (ef) begin
      chk("R6 status word", 64'(flt_status), wr ? 64'hD082_0000 : 64'hD086_0000);
      chk("R6 fault address", 64'(flt_addr), 64'(va & 32'hFFFF_F000));
    end
    hold = $urandom % 3;
    repeat (hold) begin
      @(negedge clk);
      chk("R7 held response", {26'h0, rsp_valid, rsp_fault, rsp_paddr}, {26'h0, 1'b1, ef, epa});
      chk("R6 single strobe", 64'(flt_strobe), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R1 idle after response", 64'(busy), 0);
    chk("R6 strobe count", 64'(strobes - s0), 64'(ef));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 got=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) pt[i] = $urandom;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", 64'(busy), 0);
    chk("R9 ready", 64'(req_ready), 1);
    chk("R9 rsp_valid", 64'(rsp_valid), 0);
    chk("R9 mem_req_valid", 64'(mem_req_valid), 0);
    chk("R9 flt_strobe", 64'(flt_strobe), 0);
    rst_n = 1'b1;
    // directed corner cases
    cfg_base = 32'h0123_4400; cfg_win = 3'd0;
    pt[0] = 32'h0000_0085;           // invalid, other bits set: R5 read fault
    pt[1] = 32'hABCD_EF83;           // valid, not writable
    pt[2] = 32'h1234_5606;           // valid and writable
    run(gen_va(3'd0, 0, 12'h123), 1'b0, 1'b0);
    run(gen_va(3'd0, 1, 12'hFFF), 1'b1, 1'b0);  // R5 write to read-only
    run(gen_va(3'd0, 1, 12'hFFF), 1'b0, 1'b0);  // R5 read of read-only ok, R4 max offset
    run(gen_va(3'd0, 2, 12'h000), 1'b1, 1'b0);
    cfg_win = 3'd7;
    run(gen_va(3'd7, 63, 12'h800), 1'b0, 1'b0);
    run(gen_va(3'd7, 2, 12'h004), 1'b1, 1'b1);  // R2 config changes mid-walk
    // constrained random
    for (int n = 0; n < 300; n++) begin
      if (n % 50 == 0) for (int i = 0; i < 64; i++) pt[i] = $urandom;
      run(gen_va(cfg_win, $urandom % 64, 12'($urandom)), 1'($urandom), ($urandom % 4) == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule